// File: doc/BRIEF.md
# ECC Error Capture Register

This block sits beside a SECDED checker on the memory read path and keeps a record of the first ECC event it reports. When the checker pulses its correctable or uncorrectable strobe, the block stores the upper bits of the failing physical address and the 8-bit syndrome in one 32-bit register. It also sets a flag that shows which kind of error occurred. After that, the record is frozen. No later event can overwrite it until software clears both flags in a single write.

The same register carries the control bits that steer what happens around an error. Two enables route a held correctable error to a non-maskable interrupt request and a held uncorrectable error to a bus-error request. Both requests are levels. A scrub-disable bit tells the write-back path whether corrected read data may be written back to memory. Software reads and writes the register through a plain word interface with byte enables.

Top module: `ecc_fault_latch`

## Requirements
- R1: After reset the register reads 0x00000000. The interrupt and bus-error requests are low and scrub enable is high.
- R2: When no flag is held, a correctable strobe sets bit 0. In the same update, the register stores address bits 31:13 in register bits 30:12 and the syndrome in register bits 11:4.
- R3: When no flag is held, an uncorrectable strobe sets bit 1 and captures the address and syndrome in the same way as R2.
- R4: If both strobes arrive in the same cycle, only bit 1 is set. The two flags are never set together.
- R5: While bit 0 or bit 1 is set, further strobes leave bits 30:4 and bits 1:0 unchanged.
- R6: The flags clear only on a write that enables byte lane 0 and carries 1 in both bit 0 and bit 1. A write with 01, 10 or 00 in those bits leaves the flags as they are. Clearing the flags keeps the captured address and syndrome.
- R7: The interrupt request is high exactly when bit 0 and the enable in bit 2 are both set.
- R8: The bus-error request is high exactly when bit 1 and the enable in bit 3 are both set.
- R9: Bit 31 can be read and written. Scrub enable is its inverse, so it is high when bit 31 is 0.
- R10: A write changes only the writable bits (31, 3, 2) that lie in enabled byte lanes. Bits 30:4 are never changed by a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sbeStb | input | 1 | Correctable-error strobe from the checker |
| mbeStb | input | 1 | Uncorrectable-error strobe from the checker |
| errAddr | input | 32 | Physical address of the failing read |
| errSyn | input | 8 | Syndrome of the failing read |
| regWrEn | input | 1 | Register write strobe |
| regByteEn | input | 4 | Byte-lane enables for the write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Current register contents |
| nmiReq | output | 1 | Interrupt request for a held correctable error |
| busErrReq | output | 1 | Bus-error request for a held uncorrectable error |
| scrubEn | output | 1 | Allows write-back of corrected data |

## Verification
The bench builds the block with its default parameters: a 32-bit address, an 8-bit syndrome and a 19-bit pointer. With these values the register is exactly one 32-bit word. The address field can be driven to all ones, the zero-offset boundary falls where bit 13 is the only address bit set, and the scrub bit lies alone in the top byte lane. That last point lets the bench check byte-lane masking of bit 31 apart from the low control bits. The directed cases cover simultaneous strobes, partial clears, a capture in the same cycle as a control write, and a reset applied in the middle of a run.

// File: rtl/ecc_fault_pkg.sv
package ecc_fault_pkg;
  // Field placement inside the status/control word (decoded by software).
  localparam int SBE_BIT   = 0;
  localparam int MBE_BIT   = 1;
  localparam int NMIEN_BIT = 2;
  localparam int BERREN_BIT = 3;
  localparam int SYN_LO    = 4;

  // Strobes sent from the control module to the datapath each cycle.
  typedef struct packed {
    logic capSbe;     // record a correctable event
    logic capMbe;     // record an uncorrectable event
    logic clrFlags;   // drop both flags
    logic wrEnables;  // load the two request enables
    logic wrScrub;    // load the scrub-disable bit
  } ctlStb_t;
endpackage

// File: rtl/ecc_fault_ctrl.sv
module ecc_fault_ctrl
  import ecc_fault_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int SCRUB_BIT = 31,
  localparam int LANES = REG_W / 8,
  localparam int SCRUB_LANE = SCRUB_BIT / 8
) (
  input  logic             sbeStb,
  input  logic             mbeStb,
  input  logic             sbeHeld,
  input  logic             mbeHeld,
  input  logic             regWrEn,
  input  logic [LANES-1:0] regByteEn,
  input  logic [REG_W-1:0] regWrData,
  output ctlStb_t          stb
);
  logic lowLaneWr;
  logic slotFree;

  always_comb begin
    lowLaneWr = regWrEn && regByteEn[0];
    slotFree  = !sbeHeld && !mbeHeld;
    // Uncorrectable wins a tie; nothing is captured while a record is held.
    stb.capMbe    = slotFree && mbeStb;
    stb.capSbe    = slotFree && sbeStb && !mbeStb;
    // Both flag bits must carry a one for the clear to be honoured.
    stb.clrFlags  = lowLaneWr && regWrData[SBE_BIT] && regWrData[MBE_BIT];
    stb.wrEnables = lowLaneWr;
    stb.wrScrub   = regWrEn && regByteEn[SCRUB_LANE];
  end
endmodule

// File: rtl/ecc_fault_dp.sv
module ecc_fault_dp
  import ecc_fault_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SYN_W = 8,
  parameter int PTR_W = 19,
  localparam int PTR_LO = SYN_LO + SYN_W,
  localparam int SCRUB_BIT = PTR_LO + PTR_W,
  localparam int REG_W = SCRUB_BIT + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStb_t           stb,
  input  logic [ADDR_W-1:0] errAddr,
  input  logic [SYN_W-1:0]  errSyn,
  input  logic [REG_W-1:0]  regWrData,
  output logic              sbeHeld,
  output logic              mbeHeld,
  output logic [REG_W-1:0]  regRdData,
  output logic              nmiReq,
  output logic              busErrReq,
  output logic              scrubEn
);
  logic [PTR_W-1:0] ptrQ;
  logic [SYN_W-1:0] synQ;
  logic             nmiEnQ;
  logic             berrEnQ;
  logic             scrubDisQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ    <= '0;
      synQ    <= '0;
      sbeHeld <= 1'b0;
      mbeHeld <= 1'b0;
    end else if (stb.capSbe || stb.capMbe) begin
      ptrQ    <= errAddr[ADDR_W-1 -: PTR_W];
      synQ    <= errSyn;
      sbeHeld <= stb.capSbe;
      mbeHeld <= stb.capMbe;
    end else if (stb.clrFlags) begin
      sbeHeld <= 1'b0;
      mbeHeld <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiEnQ    <= 1'b0;
      berrEnQ   <= 1'b0;
      scrubDisQ <= 1'b0;
    end else begin
      if (stb.wrEnables) begin
        nmiEnQ  <= regWrData[NMIEN_BIT];
        berrEnQ <= regWrData[BERREN_BIT];
      end
      if (stb.wrScrub) scrubDisQ <= regWrData[SCRUB_BIT];
    end
  end

  always_comb begin
    regRdData = {scrubDisQ, ptrQ, synQ, berrEnQ, nmiEnQ, mbeHeld, sbeHeld};
    nmiReq    = sbeHeld && nmiEnQ;
    busErrReq = mbeHeld && berrEnQ;
    scrubEn   = !scrubDisQ;
  end
endmodule

// File: rtl/ecc_fault_latch.sv
module ecc_fault_latch
  import ecc_fault_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SYN_W = 8,
  parameter int PTR_W = 19,
  localparam int REG_W = SYN_LO + SYN_W + PTR_W + 1,
  localparam int LANES = REG_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sbeStb,
  input  logic              mbeStb,
  input  logic [ADDR_W-1:0] errAddr,
  input  logic [SYN_W-1:0]  errSyn,
  input  logic              regWrEn,
  input  logic [LANES-1:0]  regByteEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              nmiReq,
  output logic              busErrReq,
  output logic              scrubEn
);
  ctlStb_t stb;
  logic    sbeHeld;
  logic    mbeHeld;

  ecc_fault_ctrl #(.REG_W(REG_W), .SCRUB_BIT(REG_W-1)) uCtrl (
    .sbeStb   (sbeStb),
    .mbeStb   (mbeStb),
    .sbeHeld  (sbeHeld),
    .mbeHeld  (mbeHeld),
    .regWrEn  (regWrEn),
    .regByteEn(regByteEn),
    .regWrData(regWrData),
    .stb      (stb)
  );

  ecc_fault_dp #(.ADDR_W(ADDR_W), .SYN_W(SYN_W), .PTR_W(PTR_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .errAddr  (errAddr),
    .errSyn   (errSyn),
    .regWrData(regWrData),
    .sbeHeld  (sbeHeld),
    .mbeHeld  (mbeHeld),
    .regRdData(regRdData),
    .nmiReq   (nmiReq),
    .busErrReq(busErrReq),
    .scrubEn  (scrubEn)
  );
endmodule

// File: rtl/ecc_fault_latch_chk.sv
module ecc_fault_latch_chk #(
  parameter int ADDR_W = 32,
  parameter int SYN_W = 8,
  parameter int PTR_W = 19,
  localparam int REG_W = 4 + SYN_W + PTR_W + 1,
  localparam int LANES = REG_W / 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sbeStb,
  input logic              mbeStb,
  input logic [ADDR_W-1:0] errAddr,
  input logic [SYN_W-1:0]  errSyn,
  input logic              regWrEn,
  input logic [LANES-1:0]  regByteEn,
  input logic [REG_W-1:0]  regWrData,
  input logic [REG_W-1:0]  regRdData,
  input logic              nmiReq,
  input logic              busErrReq,
  input logic              scrubEn
);
  logic clearWrite;
  assign clearWrite = regWrEn && regByteEn[0] && regWrData[0] && regWrData[1];

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(regRdData[0] && regRdData[1])); // R4

  AST_RECORD_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    ((regRdData[0] || regRdData[1]) && !clearWrite)
    |=> ($stable(regRdData[REG_W-2:4]) && $stable(regRdData[1:0]))); // R5

  AST_MBE_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[1:0] == 2'b00 && mbeStb) |=> regRdData[1]); // R3

  AST_NMI_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq == (regRdData[0] && regRdData[2])); // R7

  AST_BUSERR_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    busErrReq == (regRdData[1] && regRdData[3])); // R8

  AST_SCRUB_POLARITY: assert property (@(posedge clk) disable iff (!rstN)
    scrubEn == !regRdData[REG_W-1]); // R9

  AST_RO_FIELDS: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !sbeStb && !mbeStb) |=> $stable(regRdData[REG_W-2:4])); // R10
endmodule

bind ecc_fault_latch ecc_fault_latch_chk #(.ADDR_W(ADDR_W), .SYN_W(SYN_W), .PTR_W(PTR_W)) uChk (.*);

// File: tb/tb_ecc_fault_latch.sv
module tb_ecc_fault_latch;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        sbe;
    logic        mbe;
    logic [31:0] addr;
    logic [7:0]  syn;
    logic        wr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] expRd;
    logic [2:0]  expOut;   // {nmiReq, busErrReq, scrubEn}
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    // R10: load both request enables
    '{1'b0,1'b0,32'h0,8'h00,1'b1,4'h1,32'h0000000C,32'h0000000C,3'b001,8'd10},
    // R2 / R7: correctable capture raises interrupt
    '{1'b1,1'b0,32'hDEADA000,8'h5A,1'b0,4'h0,32'h0,32'h6F56D5AD,3'b101,8'd2},
    // R5: later uncorrectable event ignored
    '{1'b0,1'b1,32'h12345678,8'hFF,1'b0,4'h0,32'h0,32'h6F56D5AD,3'b101,8'd5},
    // R6: clear with only bit 0
    '{1'b0,1'b0,32'h0,8'h00,1'b1,4'h1,32'h0000000D,32'h6F56D5AD,3'b101,8'd6},
    // R6: clear with only bit 1
    '{1'b0,1'b0,32'h0,8'h00,1'b1,4'h1,32'h0000000E,32'h6F56D5AD,3'b101,8'd6},
    // R6: clear with both bits keeps address and syndrome
    '{1'b0,1'b0,32'h0,8'h00,1'b1,4'h1,32'h0000000F,32'h6F56D5AC,3'b001,8'd6},
    // R4 / R8: simultaneous strobes record uncorrectable only
    '{1'b1,1'b1,32'h00002000,8'h81,1'b0,4'h0,32'h0,32'h0000181E,3'b011,8'd4},
    // R9 / R10: lane 0 masked, lane 3 sets scrub disable
    '{1'b0,1'b0,32'h0,8'h00,1'b1,4'hE,32'hFFFFFFF3,32'h8000181E,3'b010,8'd9},
    // R6: full clear, enables dropped
    '{1'b0,1'b0,32'h0,8'h00,1'b1,4'h1,32'h00000003,32'h80001810,3'b000,8'd6},
    // R2: all-ones address captured alongside an enable write
    '{1'b1,1'b0,32'hFFFFFFFF,8'h00,1'b1,4'h1,32'h00000004,32'hFFFFF005,3'b100,8'd2},
    // R9: scrub re-enabled through lane 3
    '{1'b0,1'b0,32'h0,8'h00,1'b1,4'h8,32'h00000000,32'h7FFFF005,3'b101,8'd9},
    // R7: interrupt enable off while flag held
    '{1'b0,1'b0,32'h0,8'h00,1'b1,4'h1,32'h00000000,32'h7FFFF001,3'b001,8'd7}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sbeStb = 1'b0;
  logic        mbeStb = 1'b0;
  logic [31:0] errAddr = '0;
  logic [7:0]  errSyn = '0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regByteEn = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        nmiReq;
  logic        busErrReq;
  logic        scrubEn;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  ecc_fault_latch dut (
    .clk(clk), .rstN(rstN), .sbeStb(sbeStb), .mbeStb(mbeStb),
    .errAddr(errAddr), .errSyn(errSyn), .regWrEn(regWrEn),
    .regByteEn(regByteEn), .regWrData(regWrData), .regRdData(regRdData),
    .nmiReq(nmiReq), .busErrReq(busErrReq), .scrubEn(scrubEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic checkRd(input logic [31:0] exp, input int req);
    checks++;
    if (regRdData !== exp) begin
      failures++;
      $display("FAIL R%0d regRdData actual=%h expected=%h", req, regRdData, exp);
    end
  endtask

  task automatic checkOut(input logic [2:0] exp, input int req);
    checks++;
    if ({nmiReq, busErrReq, scrubEn} !== exp) begin
      failures++;
      $display("FAIL R%0d outputs actual=%b expected=%b", req,
               {nmiReq, busErrReq, scrubEn}, exp);
    end
  endtask

  task automatic idle();
    sbeStb = 1'b0; mbeStb = 1'b0; regWrEn = 1'b0; regByteEn = '0; regWrData = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state while held in reset and just after release
    checkRd(32'h0, 1);
    checkOut(3'b001, 1);
    rstN = 1'b1;
    @(negedge clk);
    checkRd(32'h0, 1);

    for (int i = 0; i < NV; i++) begin
      sbeStb = VECS[i].sbe; mbeStb = VECS[i].mbe;
      errAddr = VECS[i].addr; errSyn = VECS[i].syn;
      regWrEn = VECS[i].wr; regByteEn = VECS[i].be; regWrData = VECS[i].wd;
      @(negedge clk);
      idle();
      checkRd(VECS[i].expRd, int'(VECS[i].req));
      checkOut(VECS[i].expOut, int'(VECS[i].req));
    end

    // R3: uncorrectable capture after a full clear
    regWrEn = 1'b1; regByteEn = 4'h1; regWrData = 32'h0000000B;
    @(negedge clk);
    idle();
    mbeStb = 1'b1; errAddr = 32'h80000000; errSyn = 8'h3C;
    @(negedge clk);
    idle();
    checkRd(32'h400003CA, 3);
    checkOut(3'b011, 3);

    // R5: correctable strobe while uncorrectable held changes nothing
    sbeStb = 1'b1; errAddr = 32'h00000000; errSyn = 8'h11;
    @(negedge clk);
    idle();
    checkRd(32'h400003CA, 5);

    // R1: reset in mid-run clears everything
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkRd(32'h0, 1);
    checkOut(3'b001, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule